// File: doc/BRIEF.md
# Interlocked Flash Mode Control Registers

This block holds the software-visible mode bits that steer an on-chip flash array through its four operating modes: program, erase, program-verify and erase-verify. There is one 8-bit register for each address bank. Bank 0 covers addresses 0x00000–0x1FFFF and bank 1 covers 0x20000–0x3FFFF. Every bit carries its own write permission. An external write-enable pin and a software enable bit must both allow the write. The two action bits, erase and program, additionally need their setup bit to be stored already. The block decodes the stored bits into per-bank mode strobes that the flash array consumes.

Several sources clear the registers, and they do not all behave alike. A reset clears everything. Hardware standby also clears everything. Software standby, a low write-enable pin, and a cleared software enable each drop the mode bits but leave the sticky error flag alone. The flash array reports errors through the sticky error input, which sets that flag.

When the on-chip flash is disabled, reads return zero and writes are dropped. The CPU side is a plain single-cycle write strobe with a bank select and a combinational read port.

Top module: `flash_mode_ctl`

## Requirements
- R1: After reset, with `ext_wen` low, both registers read 0x00 and all mode strobes are 0.
- R2: A write to the software enable bit (bank 0 bit 6) takes effect only while `ext_wen` is 1. Writes to the erase-setup (bit 5), program-setup (bit 4), erase-verify (bit 3) and program-verify (bit 2) bits take effect only while `ext_wen` is 1 and the stored software enable is 1. Otherwise they are ignored.
- R3: The erase bit (bit 1) accepts a write only when the erase-setup bit was already stored as 1 before that write. Writing erase-setup and erase together leaves erase at 0.
- R4: The program bit (bit 0) accepts a write only when the program-setup bit was already stored as 1 before that write.
- R5: The program bit is rejected, and keeps its old value, in any write that also raises another mode bit of the same register (bits 5 to 1) from 0 to 1. The other bits of that write still apply.
- R6: Software standby, hardware standby and a low `ext_wen` clear the software enable and all mode bits. A stored software enable of 0 clears every bank's mode bits on the following clock edge.
- R7: The error flag sets when `err_in` is 1 and then stays set. Software standby and a low `ext_wen` leave it set. Only hardware standby or reset clears it.
- R8: While `flash_en` is 0, `rdata` is 0x00 and writes change no register.
- R9: The strobes decode the stored bits with `ext_wen` and the stored software enable, and follow `ext_wen` within the same cycle:
  - program = program AND program-setup;
  - erase = erase AND erase-setup;
  - program-verify = program-verify;
  - erase-verify = erase-verify.
- R10: Each register has the layout bit 5 erase-setup, bit 4 program-setup, bit 3 erase-verify, bit 2 program-verify, bit 1 erase, bit 0 program. In bank 0, bit 7 reads the `ext_wen` pin level and bit 6 is the software enable. In other banks, bit 7 is the read-only error flag and bit 6 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_wen | input | 1 | External flash write-enable pin |
| flash_en | input | 1 | On-chip flash enabled |
| hw_stby | input | 1 | Hardware standby, clears everything including the error flag |
| sw_stby | input | 1 | Software standby, clears all but the error flag |
| err_in | input | 1 | Error report from the flash array |
| wr | input | 1 | Write strobe |
| sel | input | 1 | Bank register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| prog_act | output | 2 | Per-bank program mode strobe |
| erase_act | output | 2 | Per-bank erase mode strobe |
| pver_act | output | 2 | Per-bank program-verify strobe |
| ever_act | output | 2 | Per-bank erase-verify strobe |

## Verification
A write, a standby pulse or an error report is stored on the next rising edge, so its effect on `rdata` is due one cycle later. The one exception is the bank-1 clear that follows a cleared software enable: that clear needs a second edge. The read port and the strobes are combinational, so a change on `ext_wen` shows on the strobes in the same cycle. The bench drives every input on the falling edge and reads back on a later falling edge, after each register on the path has clocked. It waits three edges after reset release, to cover the two-stage reset synchronizer.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
  localparam int REG_W   = 8;
  localparam int MODE_W  = 6;
  localparam int BIT_TOP = 7;
  localparam int BIT_SWE = 6;

  // Field order matches register bits 5..0
  typedef struct packed {
    logic esu;
    logic psu;
    logic ev;
    logic pv;
    logic e;
    logic p;
  } mode_bits_t;
endpackage

// File: rtl/fmc_rst_sync.sv
module fmc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/fmc_bank_ctl.sv
module fmc_bank_ctl
  import fmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_sel,
  input  mode_bits_t wbits,
  input  logic       permit,
  input  logic       clr,
  output mode_bits_t q,
  output logic       prog_act,
  output logic       erase_act,
  output logic       pver_act,
  output logic       ever_act
);
  mode_bits_t q_nxt;
  mode_bits_t rising;
  logic       other_rise;
  logic       wr_ok;

  always_comb begin
    rising     = wbits & ~q;
    other_rise = rising.esu | rising.psu | rising.ev | rising.pv | rising.e;
    wr_ok      = wr_sel & permit;
    q_nxt      = q;
    if (clr) begin
      q_nxt = '0;
    end else if (wr_ok) begin
      q_nxt.esu = wbits.esu;
      q_nxt.psu = wbits.psu;
      q_nxt.ev  = wbits.ev;
      q_nxt.pv  = wbits.pv;
      // action bits gated by setup bits held before this write
      if (q.esu) q_nxt.e = wbits.e;
      if (q.psu && !(wbits.p && other_rise)) q_nxt.p = wbits.p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  always_comb begin
    prog_act  = q.p  & q.psu & permit;
    erase_act = q.e  & q.esu & permit;
    pver_act  = q.pv & permit;
    ever_act  = q.ev & permit;
  end
endmodule

// File: rtl/flash_mode_ctl.sv
module flash_mode_ctl
  import fmc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ext_wen,
  input  logic                 flash_en,
  input  logic                 hw_stby,
  input  logic                 sw_stby,
  input  logic                 err_in,
  input  logic                 wr,
  input  logic [SEL_W-1:0]     sel,
  input  logic [REG_W-1:0]     wdata,
  output logic [REG_W-1:0]     rdata,
  output logic [NUM_BANKS-1:0] prog_act,
  output logic [NUM_BANKS-1:0] erase_act,
  output logic [NUM_BANKS-1:0] pver_act,
  output logic [NUM_BANKS-1:0] ever_act
);
  logic rst_sync_n;
  logic swe_q, swe_nxt;
  logic err_q, err_nxt;
  logic permit, mode_clr, swe_clr;
  logic [NUM_BANKS-1:0] wr_bank;
  logic [NUM_BANKS-1:0] esu_v, psu_v, e_v, p_v;
  logic [REG_W-1:0]     rd_word [NUM_BANKS];
  mode_bits_t           wbits;
  logic                 unused_wdata_top;

  assign unused_wdata_top = wdata[BIT_TOP];
  assign wbits            = mode_bits_t'(wdata[MODE_W-1:0]);

  fmc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    permit   = ext_wen & swe_q;
    swe_clr  = hw_stby | sw_stby | ~ext_wen;
    mode_clr = swe_clr | ~swe_q;
  end

  // software enable and sticky error flag
  always_comb begin
    swe_nxt = swe_q;
    if (swe_clr)         swe_nxt = 1'b0;
    else if (wr_bank[0]) swe_nxt = wdata[BIT_SWE];
    err_nxt = hw_stby ? 1'b0 : (err_q | err_in);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      swe_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      swe_q <= swe_nxt;
      err_q <= err_nxt;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    mode_bits_t q;

    assign wr_bank[b] = wr & flash_en & (int'(sel) == b);

    fmc_bank_ctl u_bank (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .wr_sel    (wr_bank[b]),
      .wbits     (wbits),
      .permit    (permit),
      .clr       (mode_clr),
      .q         (q),
      .prog_act  (prog_act[b]),
      .erase_act (erase_act[b]),
      .pver_act  (pver_act[b]),
      .ever_act  (ever_act[b])
    );

    assign esu_v[b] = q.esu;
    assign psu_v[b] = q.psu;
    assign e_v[b]   = q.e;
    assign p_v[b]   = q.p;

    if (b == 0) begin : g_first
      assign rd_word[b] = {ext_wen, swe_q, q};
    end else begin : g_other
      assign rd_word[b] = {err_q, 1'b0, q};
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (flash_en && int'(sel) == i) rdata = rd_word[i];
    end
  end
endmodule

// File: rtl/fmc_mode_ctl_chk.sv
module fmc_mode_ctl_chk #(
  parameter int NUM_BANKS = 2
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 ext_wen,
  input logic                 hw_stby,
  input logic                 sw_stby,
  input logic                 swe_q,
  input logic                 err_q,
  input logic [NUM_BANKS-1:0] esu_v,
  input logic [NUM_BANKS-1:0] psu_v,
  input logic [NUM_BANKS-1:0] e_v,
  input logic [NUM_BANKS-1:0] p_v
);
  assert_swe_needs_pin_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(swe_q) |-> $past(ext_wen));

  assert_clear_sources_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sw_stby || hw_stby || !ext_wen) |=> !swe_q);

  assert_error_sticky_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (err_q && !hw_stby) |=> err_q);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    assert_erase_after_setup_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(e_v[b]) |-> $past(esu_v[b]));

    assert_prog_after_setup_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(p_v[b]) |-> $past(psu_v[b]));

    assert_modes_need_swe_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !swe_q |=> !(esu_v[b] || psu_v[b] || e_v[b] || p_v[b]));
  end
endmodule

bind flash_mode_ctl fmc_mode_ctl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .ext_wen    (ext_wen),
  .hw_stby    (hw_stby),
  .sw_stby    (sw_stby),
  .swe_q      (swe_q),
  .err_q      (err_q),
  .esu_v      (esu_v),
  .psu_v      (psu_v),
  .e_v        (e_v),
  .p_v        (p_v)
);

// File: tb/flash_mode_ctl_test.sv
module flash_mode_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n, ext_wen, flash_en, hw_stby, sw_stby, err_in, wr, sel;
  logic [7:0] wdata, rdata;
  logic [1:0] prog_act, erase_act, pver_act, ever_act;
  int         n_run = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  flash_mode_ctl uut (
    .clk(clk), .rst_n(rst_n), .ext_wen(ext_wen), .flash_en(flash_en),
    .hw_stby(hw_stby), .sw_stby(sw_stby), .err_in(err_in), .wr(wr),
    .sel(sel), .wdata(wdata), .rdata(rdata), .prog_act(prog_act),
    .erase_act(erase_act), .pver_act(pver_act), .ever_act(ever_act)
  );

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(string tag, logic bank, logic [7:0] exp);
    sel = bank;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic wr_reg(logic bank, logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; sel = bank; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic clean();
    @(negedge clk);
    ext_wen = 1'b0;
    @(negedge clk);
    ext_wen = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk("R1 bank0 reset", 1'b0, 8'h00);
    rd_chk("R1 bank1 reset", 1'b1, 8'h00);
    check("R1 strobes reset", {prog_act, erase_act, pver_act, ever_act}, 8'h00);
  endtask

  task automatic t_gate();
    wr_reg(1'b0, 8'h40);
    rd_chk("R2 swe blocked by pin", 1'b0, 8'h00);
    ext_wen = 1'b1;
    rd_chk("R10 pin readback", 1'b0, 8'h80);
    wr_reg(1'b1, 8'h10);
    rd_chk("R2 setup blocked without swe", 1'b1, 8'h00);
    wr_reg(1'b0, 8'h40);
    rd_chk("R2 swe set", 1'b0, 8'hC0);
    wr_reg(1'b1, 8'h7C);
    rd_chk("R10 reserved bit and setup bits", 1'b1, 8'h3C);
    check("R9 verify strobes", {6'b0, pver_act[1], ever_act[1]}, 8'h03);
    check("R9 no erase strobe", {6'b0, erase_act}, 8'h00);
  endtask

  task automatic t_erase();
    clean();
    wr_reg(1'b0, 8'h62);
    rd_chk("R2 mode bits need stored swe", 1'b0, 8'hC0);
    wr_reg(1'b0, 8'h62);
    rd_chk("R3 erase with setup same write", 1'b0, 8'hE0);
    wr_reg(1'b0, 8'h62);
    rd_chk("R3 erase after setup", 1'b0, 8'hE2);
    check("R9 erase strobe", {6'b0, erase_act}, 8'h01);
  endtask

  task automatic t_prog();
    clean();
    wr_reg(1'b0, 8'h40);
    wr_reg(1'b1, 8'h11);
    rd_chk("R4 program with setup same write", 1'b1, 8'h10);
    wr_reg(1'b1, 8'h11);
    rd_chk("R4 program after setup", 1'b1, 8'h11);
    check("R9 program strobe", {6'b0, prog_act}, 8'h02);
  endtask

  task automatic t_reject();
    clean();
    wr_reg(1'b0, 8'h40);
    wr_reg(1'b1, 8'h10);
    wr_reg(1'b1, 8'h19);
    rd_chk("R5 program rejected on rising verify", 1'b1, 8'h18);
    wr_reg(1'b1, 8'h19);
    rd_chk("R5 program accepted nothing rising", 1'b1, 8'h19);
  endtask

  task automatic t_clears();
    @(negedge clk);
    ext_wen = 1'b0;
    #1;
    check("R9 strobe drops with pin", {6'b0, prog_act}, 8'h00);
    @(negedge clk);
    ext_wen = 1'b1;
    rd_chk("R6 pin low clears swe", 1'b0, 8'h80);
    rd_chk("R6 pin low clears modes", 1'b1, 8'h00);
    wr_reg(1'b0, 8'h40);
    wr_reg(1'b1, 8'h10);
    sw_stby = 1'b1;
    @(negedge clk);
    sw_stby = 1'b0;
    rd_chk("R6 sw standby swe", 1'b0, 8'h80);
    rd_chk("R6 sw standby modes", 1'b1, 8'h00);
    wr_reg(1'b0, 8'h40);
    wr_reg(1'b1, 8'h10);
    hw_stby = 1'b1;
    @(negedge clk);
    hw_stby = 1'b0;
    rd_chk("R6 hw standby modes", 1'b1, 8'h00);
    wr_reg(1'b0, 8'h40);
    wr_reg(1'b1, 8'h10);
    wr_reg(1'b0, 8'h00);
    @(negedge clk);
    rd_chk("R6 swe cleared clears bank1", 1'b1, 8'h00);
  endtask

  task automatic t_err();
    clean();
    err_in = 1'b1;
    @(negedge clk);
    err_in = 1'b0;
    rd_chk("R7 error flag set", 1'b1, 8'h80);
    sw_stby = 1'b1;
    @(negedge clk);
    sw_stby = 1'b0;
    ext_wen = 1'b0;
    @(negedge clk);
    ext_wen = 1'b1;
    rd_chk("R7 error survives soft clears", 1'b1, 8'h80);
    hw_stby = 1'b1;
    @(negedge clk);
    hw_stby = 1'b0;
    rd_chk("R7 hw standby clears error", 1'b1, 8'h00);
    err_in = 1'b1;
    @(negedge clk);
    err_in = 1'b0;
    do_reset();
    rd_chk("R7 reset clears error", 1'b1, 8'h00);
  endtask

  task automatic t_disabled();
    clean();
    flash_en = 1'b0;
    rd_chk("R8 disabled read zero", 1'b0, 8'h00);
    wr_reg(1'b0, 8'h40);
    flash_en = 1'b1;
    rd_chk("R8 disabled write dropped", 1'b0, 8'h80);
  endtask

  initial begin
    rst_n = 1'b0; ext_wen = 1'b0; flash_en = 1'b1; hw_stby = 1'b0;
    sw_stby = 1'b0; err_in = 1'b0; wr = 1'b0; sel = 1'b0; wdata = 8'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_gate();
    t_erase();
    t_prog();
    t_reject();
    t_clears();
    t_err();
    t_disabled();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule